// File: doc/BRIEF.md
# Shadowed Clock Register Access Controller

This block is the register-side front end of a timekeeping device. A byte-level serial slave in front of it turns bus activity into start, stop and byte-valid events. This block reads those events and decodes the device select byte and a two-byte register address. It acknowledges or refuses each byte and serves read data from a small register space. That space holds one control byte, a bank of time bytes and a volatile status byte.

The block never reads or writes the running time counters byte by byte. A read takes a copy of the whole time vector when the read select is acknowledged, and the bytes are served from that copy. A write takes a copy when the low address byte is acknowledged, and incoming bytes patch that copy. The patched copy is handed to the counters in one pulse, and only at a stop that closes a valid write.

Changes to the control and time bytes are guarded by two enable latches in the status byte. The first latch must be set before the second one can be set. A committed change starts a busy period of fixed length that stands in for the nonvolatile store. The second latch clears when that period ends.

Top module: `clkreg_front`

## Requirements
- R1: A select byte whose upper seven bits are 1101111 is acknowledged (bit 0 = 1 selects read, 0 selects write). Any other select byte is refused, and later bytes get no acknowledge decision until the next start. Each decision appears on ack_vld_o/ack_o for one cycle, the cycle after byte_vld_i.
- R2: After a write select, two address bytes follow, high byte first. The address is accepted only if it is at most 003Fh. Otherwise the low byte is refused and the transfer is ignored.
- R3: A read select copies time_i at its acknowledge. The time byte at address 30h+k reads as bits [8k+7:8k] of that copy, and stays unchanged while time_i moves.
- R4: The low address acknowledge copies time_i into a staging copy, and written time bytes replace entries in it. A stop after a valid write, with RWEL=1 and at least one time byte written, gives a one-cycle time_load_o (the cycle after stop) with time_val_o equal to the staging copy. Unwritten bytes keep their copied value. A refused byte or a repeated start drops the write.
- R5: Time addresses 30h–37h wrap from 37h back to 30h. Control address 10h stays at 10h. Other undefined addresses advance by one. This holds for reads and writes.
- R6: Status (3Fh) allows one byte per transfer. Advancing a read past it ends the read (rd_act_o falls). A second data byte written to it is refused, and the whole write is dropped.
- R7: Both latches are 0 after reset. At a valid stop, status value 02h sets WEL and clears RWEL. 06h sets both only if WEL was already 1. 00h clears both. Any other value changes nothing. RWEL is never 1 while WEL is 0.
- R8: With WEL=0, a data byte to control or time is refused and the write is dropped. Status writes need neither latch.
- R9: A commit of control or time bytes starts nv_busy_o for NV_CYCLES cycles, and RWEL clears when the period ends. During the period, write selects are refused and read selects are acknowledged.
- R10: A status read returns bit 7 = batt_i, bits 6..3 = 0, bit 2 = RWEL, bit 1 = WEL, bit 0 = fail_i.
- R11: After reading, the pointer holds the next address (with R5 wrapping). A read select without an address continues from there.
- R12: Data bytes to undefined addresses are acknowledged but change nothing, and such addresses read as 00h.
- R13: A written control byte reaches ctrl_o at the same valid stop and under the same RWEL condition as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start or repeated start event |
| stop_i | input | 1 | Stop event |
| byte_vld_i | input | 1 | A byte from the master is in byte_i |
| byte_i | input | 8 | Received byte |
| rd_next_i | input | 1 | Master acknowledged the current read byte |
| time_i | input | 8*TIME_N | Running time, byte k at address 30h+k |
| batt_i | input | 1 | Running from backup supply |
| fail_i | input | 1 | Clock-fail flag |
| ack_vld_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_act_o | output | 1 | A read transfer is active |
| rd_data_o | output | 8 | Byte at the current pointer |
| time_load_o | output | 1 | Load pulse to the time counters |
| time_val_o | output | 8*TIME_N | Value to load |
| ctrl_o | output | 8 | Control byte |
| nv_busy_o | output | 1 | Nonvolatile busy period |

## Verification
The assertions take for granted that the event inputs are one-cycle pulses that never coincide: start_i, stop_i, byte_vld_i and rd_next_i are never high in the same cycle. They also assume rd_next_i arrives only during a read. The bench drives each event alone for one cycle, with an idle cycle after every byte. It issues rd_next_i only after a read select. A reference model in the bench compares every output on every clock while directed sequences walk through the enable handshake, wraps, aborts and the busy period.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
    localparam int REG_AW = 6;
    localparam logic [6:0] DEV_ID = 7'b1101111;
    localparam logic [REG_AW-1:0] CTRL_ADR = 6'h10;
    localparam logic [REG_AW-1:0] TIME_ADR = 6'h30;
    localparam logic [REG_AW-1:0] STAT_ADR = 6'h3F;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEL, PH_AHI, PH_ALO, PH_WDAT, PH_READ, PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        SEC_NONE, SEC_CTRL, SEC_TIME, SEC_STAT
    } sect_e;
endpackage

// File: rtl/clkreg_addr_map.sv
module clkreg_addr_map
    import clkreg_pkg::*;
#(
    parameter int TIME_N = 8,
    localparam int IW = $clog2(TIME_N)
) (
    input  logic [REG_AW-1:0] ptr_i,
    output sect_e             sect_o,
    output logic [IW-1:0]     tidx_o,
    output logic [REG_AW-1:0] nxt_o
);
    logic [REG_AW-1:0] off;

    always_comb begin
        off    = ptr_i - TIME_ADR;
        tidx_o = off[IW-1:0];
        sect_o = SEC_NONE;
        nxt_o  = ptr_i + REG_AW'(1);
        if (ptr_i == CTRL_ADR) begin
            sect_o = SEC_CTRL;
            nxt_o  = CTRL_ADR;
        end else if (ptr_i >= TIME_ADR && int'(off) < TIME_N) begin
            sect_o = SEC_TIME;
            if (int'(off) == TIME_N - 1) nxt_o = TIME_ADR;
        end else if (ptr_i == STAT_ADR) begin
            sect_o = SEC_STAT;
            nxt_o  = STAT_ADR;
        end
    end
endmodule

// File: rtl/clkreg_nv_timer.sv
module clkreg_nv_timer #(
    parameter int CYCLES = 200,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
        if (kick_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign done_o = tmr_q.busy && (tmr_q.cnt == '0);

    AST_NV_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |-> !busy_o); // R9
endmodule

// File: rtl/clkreg_wen_latch.sv
module clkreg_wen_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] val_i,
    input  logic       clr_i,
    output logic       wel_o,
    output logic       rwel_o
);
    typedef struct packed {
        logic wel;
        logic rwel;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr_i) lat_d.rwel = 1'b0;
        if (wr_i) begin
            case (val_i)
                8'h02: begin
                    lat_d.wel  = 1'b1;
                    lat_d.rwel = 1'b0;
                end
                8'h06: begin
                    if (lat_q.wel) begin
                        lat_d.wel  = 1'b1;
                        lat_d.rwel = 1'b1;
                    end
                end
                8'h00: begin
                    lat_d.wel  = 1'b0;
                    lat_d.rwel = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else lat_q <= lat_d;
    end

    assign wel_o  = lat_q.wel;
    assign rwel_o = lat_q.rwel;

    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_o |-> wel_o); // R7
    AST_RWEL_RISE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rwel_o) |-> ($past(wr_i) && $past(val_i) == 8'h06 && $past(wel_o))); // R7
endmodule

// File: rtl/clkreg_front.sv
module clkreg_front
    import clkreg_pkg::*;
#(
    parameter int TIME_N = 8,
    parameter int NV_CYCLES = 200,
    localparam int TW = 8 * TIME_N,
    localparam int IW = $clog2(TIME_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          rd_next_i,
    input  logic [TW-1:0] time_i,
    input  logic          batt_i,
    input  logic          fail_i,
    output logic          ack_vld_o,
    output logic          ack_o,
    output logic          rd_act_o,
    output logic [7:0]    rd_data_o,
    output logic          time_load_o,
    output logic [TW-1:0] time_val_o,
    output logic [7:0]    ctrl_o,
    output logic          nv_busy_o
);
    localparam logic [REG_AW-1:0] TIME_LAST = TIME_ADR + REG_AW'(TIME_N - 1);

    typedef struct packed {
        phase_e            ph;
        logic [REG_AW-1:0] ptr;
        logic [7:0]        ahi;
        logic [TW-1:0]     hold;
        logic [TW-1:0]     stage;
        logic [7:0]        cstage;
        logic              tdirty;
        logic              cdirty;
        logic              sdirty;
        logic [7:0]        sval;
        logic              ack_vld;
        logic              ack;
        logic [7:0]        ctrl;
        logic              tload;
    } st_t;

    st_t st_d, st_q;

    sect_e             sect;
    logic [IW-1:0]     tidx;
    logic [REG_AW-1:0] nxt;
    logic              wel, rwel, nv_busy, nv_done, stat_wr, nv_kick;
    logic [7:0]        rd_mux;

    clkreg_addr_map #(.TIME_N(TIME_N)) map_i (
        .ptr_i (st_q.ptr),
        .sect_o(sect),
        .tidx_o(tidx),
        .nxt_o (nxt)
    );

    clkreg_nv_timer #(.CYCLES(NV_CYCLES)) nvt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .kick_i(nv_kick),
        .busy_o(nv_busy),
        .done_o(nv_done)
    );

    clkreg_wen_latch wen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (stat_wr),
        .val_i (st_q.sval),
        .clr_i (nv_done),
        .wel_o (wel),
        .rwel_o(rwel)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ack_vld = 1'b0;
        st_d.ack     = 1'b0;
        st_d.tload   = 1'b0;
        stat_wr      = 1'b0;
        nv_kick      = 1'b0;
        if (start_i) begin
            st_d.ph = PH_SEL;
        end else if (stop_i) begin
            if (st_q.ph == PH_WDAT) begin
                stat_wr = st_q.sdirty;
                if (rwel && (st_q.tdirty || st_q.cdirty)) begin
                    nv_kick    = 1'b1;
                    st_d.tload = st_q.tdirty;
                    if (st_q.cdirty) st_d.ctrl = st_q.cstage;
                end
            end
            st_d.ph = PH_IDLE;
        end else if (byte_vld_i) begin
            case (st_q.ph)
                PH_SEL: begin
                    st_d.ack_vld = 1'b1;
                    if (byte_i[7:1] == DEV_ID && (byte_i[0] || !nv_busy)) begin
                        st_d.ack = 1'b1;
                        if (byte_i[0]) begin
                            st_d.ph   = PH_READ;
                            st_d.hold = time_i;
                        end else begin
                            st_d.ph = PH_AHI;
                        end
                    end else begin
                        st_d.ph = PH_SKIP;
                    end
                end
                PH_AHI: begin
                    st_d.ack_vld = 1'b1;
                    st_d.ack     = 1'b1;
                    st_d.ahi     = byte_i;
                    st_d.ph      = PH_ALO;
                end
                PH_ALO: begin
                    st_d.ack_vld = 1'b1;
                    if (st_q.ahi == 8'h00 && byte_i[7:REG_AW] == '0) begin
                        st_d.ack    = 1'b1;
                        st_d.ptr    = byte_i[REG_AW-1:0];
                        st_d.stage  = time_i;
                        st_d.cstage = st_q.ctrl;
                        st_d.tdirty = 1'b0;
                        st_d.cdirty = 1'b0;
                        st_d.sdirty = 1'b0;
                        st_d.ph     = PH_WDAT;
                    end else begin
                        st_d.ph = PH_SKIP;
                    end
                end
                PH_WDAT: begin
                    st_d.ack_vld = 1'b1;
                    case (sect)
                        SEC_STAT: begin
                            if (!st_q.sdirty) begin
                                st_d.ack    = 1'b1;
                                st_d.sval   = byte_i;
                                st_d.sdirty = 1'b1;
                                st_d.ptr    = nxt;
                            end else begin
                                st_d.ph = PH_SKIP;
                            end
                        end
                        SEC_CTRL: begin
                            if (wel) begin
                                st_d.ack    = 1'b1;
                                st_d.cstage = byte_i;
                                st_d.cdirty = 1'b1;
                                st_d.ptr    = nxt;
                            end else begin
                                st_d.ph = PH_SKIP;
                            end
                        end
                        SEC_TIME: begin
                            if (wel) begin
                                st_d.ack                       = 1'b1;
                                st_d.stage[8*int'(tidx) +: 8] = byte_i;
                                st_d.tdirty                    = 1'b1;
                                st_d.ptr                       = nxt;
                            end else begin
                                st_d.ph = PH_SKIP;
                            end
                        end
                        default: begin
                            st_d.ack = 1'b1;
                            st_d.ptr = nxt;
                        end
                    endcase
                end
                default: ;
            endcase
        end else if (rd_next_i && st_q.ph == PH_READ) begin
            st_d.ptr = nxt;
            if (sect == SEC_STAT) st_d.ph = PH_SKIP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else st_q <= st_d;
    end

    always_comb begin
        case (sect)
            SEC_CTRL: rd_mux = st_q.ctrl;
            SEC_TIME: rd_mux = st_q.hold[8*int'(tidx) +: 8];
            SEC_STAT: rd_mux = {batt_i, 4'b0000, rwel, wel, fail_i};
            default:  rd_mux = 8'h00;
        endcase
    end

    assign rd_act_o    = (st_q.ph == PH_READ);
    assign rd_data_o   = rd_act_o ? rd_mux : 8'h00;
    assign ack_vld_o   = st_q.ack_vld;
    assign ack_o       = st_q.ack;
    assign time_load_o = st_q.tload;
    assign time_val_o  = st_q.stage;
    assign ctrl_o      = st_q.ctrl;
    assign nv_busy_o   = nv_busy;

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i)); // R1
    AST_LOAD_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        time_load_o |-> ($past(stop_i) && $past(rwel))); // R4
    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_READ && $past(st_q.ph) == PH_READ) |-> $stable(st_q.hold)); // R3
    AST_TIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_READ && rd_next_i && !start_i && !stop_i && st_q.ptr == TIME_LAST)
        |=> st_q.ptr == TIME_ADR); // R5
endmodule

// File: tb/clkreg_front_tb_top.sv
`timescale 1ns/1ps
module clkreg_front_tb_top;
    localparam int NV = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, stop_i = 0, byte_vld_i = 0, rd_next_i = 0;
    logic [7:0]  byte_i = 0;
    logic [63:0] tval = 64'h2026_0305_0214_3518;
    logic        tmove = 0;
    logic        batt_i = 0, fail_i = 0;
    logic        ack_vld_o, ack_o, rd_act_o, time_load_o, nv_busy_o;
    logic [7:0]  rd_data_o, ctrl_o;
    logic [63:0] time_val_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    clkreg_front #(.TIME_N(8), .NV_CYCLES(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_next_i(rd_next_i),
        .time_i(tval), .batt_i(batt_i), .fail_i(fail_i),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_act_o(rd_act_o),
        .rd_data_o(rd_data_o), .time_load_o(time_load_o), .time_val_o(time_val_o),
        .ctrl_o(ctrl_o), .nv_busy_o(nv_busy_o)
    );

    always @(negedge clk) begin
        #1;
        if (tmove) tval <= tval + 64'h0000_0000_0001_0203;
    end

    // ---------------- behavioural reference model ----------------
    int         m_mode, m_ptr, m_busy_left;
    logic [7:0] m_ahi, m_cstg, m_ctrl, m_sv;
    logic [7:0] m_hold [8];
    logic [7:0] m_stg [8];
    logic       m_td, m_cd, m_sd, m_wel, m_rwel, m_ackv, m_ack, m_load;
    logic [63:0] m_loadv;

    function automatic int sect_of(int p);
        if (p == 16) return 1;
        if (p >= 48 && p <= 55) return 2;
        if (p == 63) return 3;
        return 0;
    endfunction

    function automatic int next_of(int p);
        int s = sect_of(p);
        if (s == 1 || s == 3) return p;
        if (s == 2) return (p == 55) ? 48 : p + 1;
        return (p + 1) % 64;
    endfunction

    always @(posedge clk) begin
        bit ob, ow, orw, swr, kick;
        int s;
        if (!rst_n) begin
            m_mode = 0; m_ptr = 0; m_busy_left = 0; m_ahi = 0; m_cstg = 0;
            m_ctrl = 0; m_sv = 0; m_td = 0; m_cd = 0; m_sd = 0; m_wel = 0;
            m_rwel = 0; m_ackv = 0; m_ack = 0; m_load = 0; m_loadv = 0;
            for (int k = 0; k < 8; k++) begin m_hold[k] = 0; m_stg[k] = 0; end
        end else begin
            ob = (m_busy_left > 0); ow = m_wel; orw = m_rwel; swr = 0; kick = 0;
            m_ackv = 0; m_ack = 0; m_load = 0;
            s = sect_of(m_ptr);
            if (start_i) m_mode = 1;
            else if (stop_i) begin
                if (m_mode == 4) begin
                    swr = m_sd;
                    if (orw && (m_td || m_cd)) begin
                        kick = 1;
                        if (m_td) begin
                            m_load = 1;
                            for (int k = 0; k < 8; k++) m_loadv[8*k +: 8] = m_stg[k];
                        end
                        if (m_cd) m_ctrl = m_cstg;
                    end
                end
                m_mode = 0;
            end else if (byte_vld_i) begin
                case (m_mode)
                    1: begin
                        m_ackv = 1;
                        if (byte_i[7:1] == 7'b1101111 && (byte_i[0] || !ob)) begin
                            m_ack = 1;
                            if (byte_i[0]) begin
                                m_mode = 5;
                                for (int k = 0; k < 8; k++) m_hold[k] = tval[8*k +: 8];
                            end else m_mode = 2;
                        end else m_mode = 6;
                    end
                    2: begin m_ackv = 1; m_ack = 1; m_ahi = byte_i; m_mode = 3; end
                    3: begin
                        m_ackv = 1;
                        if (m_ahi == 0 && byte_i <= 8'h3F) begin
                            m_ack = 1; m_ptr = int'(byte_i); m_cstg = m_ctrl;
                            for (int k = 0; k < 8; k++) m_stg[k] = tval[8*k +: 8];
                            m_td = 0; m_cd = 0; m_sd = 0; m_mode = 4;
                        end else m_mode = 6;
                    end
                    4: begin
                        m_ackv = 1;
                        if (s == 3) begin
                            if (!m_sd) begin m_ack = 1; m_sv = byte_i; m_sd = 1; end
                            else m_mode = 6;
                        end else if (s == 1 || s == 2) begin
                            if (ow) begin
                                m_ack = 1;
                                if (s == 1) begin m_cstg = byte_i; m_cd = 1; end
                                else begin m_stg[m_ptr-48] = byte_i; m_td = 1; end
                                m_ptr = next_of(m_ptr);
                            end else m_mode = 6;
                        end else begin
                            m_ack = 1; m_ptr = next_of(m_ptr);
                        end
                    end
                    default: ;
                endcase
            end else if (rd_next_i && m_mode == 5) begin
                m_ptr = next_of(m_ptr);
                if (s == 3) m_mode = 6;
            end
            if (m_busy_left > 0) begin
                m_busy_left--;
                if (m_busy_left == 0) m_rwel = 0;
            end
            if (swr) begin
                if (m_sv == 8'h02) begin m_wel = 1; m_rwel = 0; end
                else if (m_sv == 8'h06 && ow) begin m_wel = 1; m_rwel = 1; end
                else if (m_sv == 8'h00) begin m_wel = 0; m_rwel = 0; end
            end
            if (kick) m_busy_left = NV;
        end
    end

    function automatic logic [7:0] m_rd();
        case (sect_of(m_ptr))
            1: return m_ctrl;
            2: return m_hold[m_ptr-48];
            3: return {batt_i, 4'b0000, m_rwel, m_wel, fail_i};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("ack_vld", 64'(ack_vld_o), 64'(m_ackv));
            if (m_ackv) chk("ack", 64'(ack_o), 64'(m_ack));
            chk("rd_act", 64'(rd_act_o), 64'(m_mode == 5));
            if (m_mode == 5) chk("rd_data", 64'(rd_data_o), 64'(m_rd()));
            chk("time_load", 64'(time_load_o), 64'(m_load));
            if (m_load) chk("time_val", time_val_o, m_loadv);
            chk("ctrl", 64'(ctrl_o), 64'(m_ctrl));
            chk("nv_busy", 64'(nv_busy_o), 64'(m_busy_left > 0));
        end
    end

    // ---------------- stimulus ----------------
    logic       last_ackv, last_ack, last_load;
    logic [63:0] last_val;

    task automatic step();
        @(posedge clk); #2;
        start_i = 0; stop_i = 0; byte_vld_i = 0; rd_next_i = 0;
    endtask
    task automatic do_start(); start_i = 1; step(); endtask
    task automatic do_stop();
        stop_i = 1; step();
        last_load = time_load_o; last_val = time_val_o;
        step();
    endtask
    task automatic do_byte(input logic [7:0] b);
        byte_vld_i = 1; byte_i = b; step();
        last_ackv = ack_vld_o; last_ack = ack_o;
        step();
    endtask
    task automatic do_next(); rd_next_i = 1; step(); endtask
    task automatic start_wr(input logic [7:0] a);
        do_start(); do_byte(8'hDE); do_byte(8'h00); do_byte(a);
    endtask
    task automatic rd_at(input logic [7:0] a);
        start_wr(a); do_start(); do_byte(8'hDF);
    endtask
    task automatic wr_stat(input logic [7:0] v);
        start_wr(8'h3F); do_byte(v); do_stop();
    endtask
    task automatic rd_stat(output logic [7:0] v);
        rd_at(8'h3F); v = rd_data_o; do_stop();
    endtask
    task automatic wait_nv(); repeat (NV + 4) step(); endtask

    initial begin
        logic [7:0] v, r0;
        logic [63:0] exp;
        repeat (4) step();
        rst_n = 1; step();
        cur_req = "R7";
        chk("reset ctrl", 64'(ctrl_o), 0);
        chk("reset busy", 64'(nv_busy_o), 0);
        chk("reset ack", 64'(ack_vld_o), 0);

        cur_req = "R10";
        batt_i = 1; fail_i = 1;
        rd_stat(v); chk("status read", 64'(v), 64'h81);
        batt_i = 0; fail_i = 0;

        cur_req = "R8";
        start_wr(8'h30); do_byte(8'h11);
        chk("time byte refused", 64'(last_ack), 0);
        do_stop(); chk("no load", 64'(last_load), 0);

        cur_req = "R7";
        wr_stat(8'h06); rd_stat(v); chk("06 without WEL", 64'(v), 0);
        wr_stat(8'h02); rd_stat(v); chk("02 sets WEL", 64'(v), 64'h02);
        wr_stat(8'h06); rd_stat(v); chk("06 after 02", 64'(v), 64'h06);
        wr_stat(8'h84); rd_stat(v); chk("other value ignored", 64'(v), 64'h06);
        wr_stat(8'h00); rd_stat(v); chk("00 clears", 64'(v), 0);
        wr_stat(8'h02); wr_stat(8'h06);

        cur_req = "R4";
        start_wr(8'h31); do_byte(8'h45); do_byte(8'h12); do_stop();
        exp = tval; exp[15:8] = 8'h45; exp[23:16] = 8'h12;
        chk("load pulse", 64'(last_load), 1);
        chk("load value", last_val, exp);
        cur_req = "R9";
        chk("busy after commit", 64'(nv_busy_o), 1);
        do_start(); do_byte(8'hDE); chk("write select while busy", 64'(last_ack), 0); do_stop();
        do_start(); do_byte(8'hDF); chk("read select while busy", 64'(last_ack), 1); do_stop();
        wait_nv();
        chk("busy ended", 64'(nv_busy_o), 0);
        rd_stat(v); chk("RWEL cleared", 64'(v), 64'h02);

        cur_req = "R13";
        wr_stat(8'h06); start_wr(8'h10); do_byte(8'hA5); do_stop();
        chk("ctrl committed", 64'(ctrl_o), 64'hA5);
        wait_nv();

        cur_req = "R5";
        wr_stat(8'h06); start_wr(8'h37); do_byte(8'h77); do_byte(8'h99); do_stop();
        exp = tval; exp[63:56] = 8'h77; exp[7:0] = 8'h99;
        chk("write wrap", last_val, exp);
        wait_nv();
        rd_at(8'h10); r0 = rd_data_o; do_next();
        chk("ctrl read stays", 64'(rd_data_o), 64'(r0)); do_stop();

        cur_req = "R3";
        tmove = 1;
        rd_at(8'h36); do_next(); do_next();
        r0 = rd_data_o; repeat (6) step();
        chk("snapshot stable", 64'(rd_data_o), 64'(r0));
        do_next(); do_stop();
        tmove = 0; step(); step();
        cur_req = "R11";
        do_start(); do_byte(8'hDF);
        chk("current address read", 64'(rd_data_o), 64'(tval[15:8]));
        do_stop();

        cur_req = "R6";
        rd_at(8'h3F); do_next();
        chk("read ends after status", 64'(rd_act_o), 0); do_stop();
        wr_stat(8'h00);
        start_wr(8'h3F); do_byte(8'h02); do_byte(8'h06);
        chk("second status byte refused", 64'(last_ack), 0); do_stop();
        rd_stat(v); chk("status unchanged", 64'(v), 0);

        cur_req = "R12";
        wr_stat(8'h02);
        start_wr(8'h20); do_byte(8'h5A);
        chk("undefined acked", 64'(last_ack), 1); do_stop();
        chk("undefined no load", 64'(last_load), 0);
        rd_at(8'h20); chk("undefined reads 0", 64'(rd_data_o), 0); do_stop();

        cur_req = "R2";
        start_wr(8'h40); chk("address 40h refused", 64'(last_ack), 0); do_stop();
        start_wr(8'h10); do_stop();
        do_start(); do_byte(8'hDE); do_byte(8'h01); do_byte(8'h10);
        chk("high byte nonzero refused", 64'(last_ack), 0); do_stop();

        cur_req = "R1";
        do_start(); do_byte(8'hA0);
        chk("bad select valid", 64'(last_ackv), 1);
        chk("bad select refused", 64'(last_ack), 0);
        do_byte(8'hDE); chk("ignored after bad select", 64'(last_ackv), 0); do_stop();

        cur_req = "R4";
        wr_stat(8'h06); start_wr(8'h30); do_byte(8'h55);
        do_start(); do_byte(8'hDF); do_stop();
        chk("aborted write no load", 64'(last_load), 0);

        repeat (4) step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule